// File: doc/BRIEF.md
# Sigma-Delta Converter Serial Host Sequencer

This block is the host side of a four-wire serial link to a sigma-delta converter. It drives chip select, serial clock and serial data out, and it reads one shared return line that carries both the end-of-conversion indication and the result bits. A two-bit mode input picks one of three ways to acquire results. A single conversion powers the converter up, waits, and then fetches one word. Polled continuous operation fetches each new word with a read command. Streaming operation needs no command per word. A separate request sends the converter's 32-ones interface reset.

Results leave on a valid/ready stream. A word stays presented, unchanged, until the consumer takes it with `res_ready_i` high on a clock edge while `res_valid_o` is high. While that slot is full, the sequencer starts no new read. This back-pressure can cost conversions in the converter. In polled and streaming operation, such a loss is reported with a one-cycle overrun pulse. The serial clock is the system clock divided by `2*CLK_DIV`. It idles high. The host changes its output bit on the falling edge and samples the return line on the rising edge. All words go MSB first. The return line is taken to be synchronous to `clk`.

Top module: `adc_host_seq`

## Requirements
- R1: After reset, `cs_n_o`=1, `sclk_o`=1, `din_o`=0, `res_valid_o`=0, `busy_o`=0 and `overrun_o`=0.
- R2: Whenever `cs_n_o` is high, `sclk_o` is high. Every low phase of `sclk_o` lasts exactly `CLK_DIV` system clocks.
- R3: A pulse on `rst_seq_i` while idle sends 32 ones with `cs_n_o` low and then releases `cs_n_o`.
- R4: Mode 0 (single) sends the bytes 0x08, 0x20, 0x0A. This is the mode write, with the select field in word bits 15:13 set to 001. The block then waits at least `PWRUP_CYC` clocks with no serial clock. Once the return line is low it sends 0x58, reads one word and releases `cs_n_o`.
- R5: Mode 1 (polled) sends 0x08, 0x00, 0x0A. For each low on the return line it then sends 0x58 and reads a word. It keeps `cs_n_o` low until `stop_i`, and then returns to idle.
- R6: Mode 2 (streaming) sends 0x08, 0x00, 0x0A, 0x5C. For each later low on the return line it applies only `RESULT_W` clocks and sends no command.
- R7: During every result read, and whenever `cs_n_o` is high, `din_o` is 0.
- R8: After `stop_i` in streaming mode, the exit byte 0x58 is sent only once the return line is low. The block then releases `cs_n_o`, goes idle and presents no result.
- R9: `res_data_o` holds still while `res_valid_o` is high and `res_ready_i` is low. No read starts while the slot is full.
- R10: In modes 1 and 2, a low on the return line while the result slot is full raises `overrun_o` for exactly one clock per event.
- R11: The presented result equals the `RESULT_W` bits sampled MSB first on the rising serial clock edges of the read.
- R12: `start_i` and `rst_seq_i` have no effect while `busy_o` is high. Mode 3 does not start anything.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | Acquisition mode: 0 single, 1 polled, 2 streaming |
| start_i | input | 1 | Start the selected mode (only acted on when idle) |
| stop_i | input | 1 | Leave polled or streaming operation |
| rst_seq_i | input | 1 | Send the 32-ones interface reset (only when idle) |
| busy_o | output | 1 | Sequencer is not idle |
| cs_n_o | output | 1 | Chip select, active low |
| sclk_o | output | 1 | Serial clock, idles high |
| din_o | output | 1 | Serial data to the converter |
| dout_rdy_i | input | 1 | Shared return line: ready indication and result bits |
| res_data_o | output | RESULT_W | Result word |
| res_valid_o | output | 1 | Result word is presented |
| res_ready_i | input | 1 | Consumer accepts the result |
| overrun_o | output | 1 | One-cycle pulse: conversion arrived while the slot was full |

## Verification
The bench contains a behavioural converter that drives result bits on falling serial clock edges. In polled mode it first lets the read command pass, and in streaming mode it does not. Each mode is run with a different result pattern, and the recorded host bit stream is compared bit by bit. This separates the single, polled and streaming command sequences, and it shows that the command-free streaming reads are exactly `RESULT_W` long. A held consumer combined with a second conversion separates a correct overrun pulse and a frozen result from a silent overwrite. A stop request given while the line is high separates an exit that waits for readiness from one sent at once.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;

  typedef enum logic [1:0] {
    ACQ_SINGLE = 2'd0,
    ACQ_POLL   = 2'd1,
    ACQ_STREAM = 2'd2,
    ACQ_NONE   = 2'd3
  } acq_mode_t;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RESET,
    ST_MODE_WR,
    ST_STREAM_ON,
    ST_POWERUP,
    ST_WAIT_RDY,
    ST_READ_CMD,
    ST_READ_DATA,
    ST_STREAM_OFF
  } seq_state_t;

  localparam logic [7:0] OP_WRITE_MODE = 8'h08;
  localparam logic [7:0] OP_READ_DATA  = 8'h58;
  localparam logic [7:0] OP_STREAM_ON  = 8'h5C;
  localparam logic [2:0] MD_CONT       = 3'b000;
  localparam logic [2:0] MD_SINGLE     = 3'b001;
  localparam int         SHIFT_W       = 32;
  localparam int         NBITS_W       = 6;

endpackage

// File: rtl/adc_sclk_div.sv
module adc_sclk_div #(
  parameter int CLK_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  output logic tick_o
);
  localparam int            CW   = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLK_DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt <= '0;
    else if (!en_i || cnt == LAST) cnt <= '0;
    else                          cnt <= cnt + 1'b1;
  end

  assign tick_o = en_i && (cnt == LAST);

endmodule

// File: rtl/adc_bit_shifter.sv
module adc_bit_shifter
  import adc_host_pkg::*;
#(
  parameter int CLK_DIV = 2,
  parameter int RX_W    = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               go_i,
  input  logic [NBITS_W-1:0] nbits_i,
  input  logic [SHIFT_W-1:0] word_i,
  input  logic               sdo_i,
  output logic               active_o,
  output logic               done_o,
  output logic               sclk_o,
  output logic               sdi_o,
  output logic [RX_W-1:0]    rx_o
);
  logic               tick;
  logic [SHIFT_W-1:0] tx;
  logic [NBITS_W-1:0] left;

  adc_sclk_div #(.CLK_DIV(CLK_DIV)) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (active_o),
    .tick_o (tick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_o <= 1'b0;
      done_o   <= 1'b0;
      sclk_o   <= 1'b1;
      sdi_o    <= 1'b0;
      tx       <= '0;
      rx_o     <= '0;
      left     <= '0;
    end else begin
      done_o <= 1'b0;
      if (!active_o) sdi_o <= 1'b0;
      if (go_i && !active_o) begin
        active_o <= 1'b1;
        tx       <= word_i;
        left     <= nbits_i;
      end else if (active_o && tick) begin
        if (sclk_o) begin
          sclk_o <= 1'b0;
          sdi_o  <= tx[SHIFT_W-1];
        end else begin
          sclk_o <= 1'b1;
          rx_o   <= {rx_o[RX_W-2:0], sdo_i};
          tx     <= {tx[SHIFT_W-2:0], 1'b0};
          left   <= left - 1'b1;
          if (left == NBITS_W'(1)) begin
            active_o <= 1'b0;
            done_o   <= 1'b1;
          end
        end
      end
    end
  end

  AST_GO_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    go_i |-> !active_o); // R2
  AST_SCLK_REST_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !active_o |-> sclk_o); // R2

endmodule

// File: rtl/adc_result_buf.sv
module adc_result_buf #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  input  logic         ready_i,
  output logic         valid_o,
  output logic [W-1:0] data_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      data_o  <= data_i;
    end else if (valid_o && ready_i) begin
      valid_o <= 1'b0;
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i) |=> (valid_o && $stable(data_o))); // R9
  AST_LOAD_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> !valid_o); // R9

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_host_pkg::*;
#(
  parameter int          RESULT_W  = 24,
  parameter int          PWRUP_CYC = 50000,
  parameter logic [12:0] MODE_LOW  = 13'h000A
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         mode_i,
  input  logic               start_i,
  input  logic               stop_i,
  input  logic               rst_seq_i,
  input  logic               rdy_i,
  input  logic               slot_full_i,
  input  logic               sh_active_i,
  input  logic               sh_done_i,
  output logic               sh_go_o,
  output logic [NBITS_W-1:0] sh_nbits_o,
  output logic [SHIFT_W-1:0] sh_word_o,
  output logic               load_o,
  output logic               cs_n_o,
  output logic               busy_o,
  output logic               overrun_o
);
  localparam int            PW       = $clog2(PWRUP_CYC + 1);
  localparam logic [PW-1:0] PWR_LAST = PW'(PWRUP_CYC - 1);

  seq_state_t    st;
  acq_mode_t     acq;
  logic          launched;
  logic          stop_pend;
  logic          ovr_seen;
  logic          ovr_cond;
  logic          shifting;
  logic [PW-1:0] pwr_cnt;
  logic [2:0]    md_field;

  assign md_field = (acq == ACQ_SINGLE) ? MD_SINGLE : MD_CONT;
  assign shifting = (st == ST_RESET) || (st == ST_MODE_WR) || (st == ST_STREAM_ON) ||
                    (st == ST_READ_CMD) || (st == ST_READ_DATA) || (st == ST_STREAM_OFF);
  assign sh_go_o  = shifting && !launched;
  assign load_o   = (st == ST_READ_DATA) && sh_done_i;
  assign busy_o   = (st != ST_IDLE);
  assign cs_n_o   = (st == ST_IDLE);
  assign ovr_cond = (st == ST_WAIT_RDY) && (acq != ACQ_SINGLE) && !rdy_i && slot_full_i;

  always_comb begin
    sh_word_o  = '0;
    sh_nbits_o = NBITS_W'(8);
    case (st)
      ST_RESET: begin
        sh_word_o  = '1;
        sh_nbits_o = NBITS_W'(32);
      end
      ST_MODE_WR: begin
        sh_word_o  = {OP_WRITE_MODE, md_field, MODE_LOW, 8'h00};
        sh_nbits_o = NBITS_W'(24);
      end
      ST_STREAM_ON:  sh_word_o = {OP_STREAM_ON, 24'h0};
      ST_READ_CMD,
      ST_STREAM_OFF: sh_word_o = {OP_READ_DATA, 24'h0};
      ST_READ_DATA:  sh_nbits_o = NBITS_W'(RESULT_W);
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      acq       <= ACQ_NONE;
      launched  <= 1'b0;
      stop_pend <= 1'b0;
      ovr_seen  <= 1'b0;
      overrun_o <= 1'b0;
      pwr_cnt   <= '0;
    end else begin
      overrun_o <= ovr_cond && !ovr_seen;
      ovr_seen  <= ovr_cond;
      if (sh_go_o)   launched <= 1'b1;
      if (sh_done_i) launched <= 1'b0;
      if (stop_i && st != ST_IDLE && acq != ACQ_SINGLE) stop_pend <= 1'b1;
      case (st)
        ST_IDLE: begin
          stop_pend <= 1'b0;
          if (rst_seq_i) begin
            st <= ST_RESET;
          end else if (start_i && acq_mode_t'(mode_i) != ACQ_NONE) begin
            acq <= acq_mode_t'(mode_i);
            st  <= ST_MODE_WR;
          end
        end
        ST_RESET: if (sh_done_i) st <= ST_IDLE;
        ST_MODE_WR: begin
          if (sh_done_i) begin
            case (acq)
              ACQ_SINGLE: begin
                st      <= ST_POWERUP;
                pwr_cnt <= '0;
              end
              ACQ_STREAM: st <= ST_STREAM_ON;
              default:    st <= ST_WAIT_RDY;
            endcase
          end
        end
        ST_STREAM_ON: if (sh_done_i) st <= ST_WAIT_RDY;
        ST_POWERUP: begin
          if (pwr_cnt == PWR_LAST) st <= ST_WAIT_RDY;
          else                     pwr_cnt <= pwr_cnt + 1'b1;
        end
        ST_WAIT_RDY: begin
          if (acq == ACQ_STREAM && stop_pend) begin
            if (!rdy_i) st <= ST_STREAM_OFF;
          end else if (acq == ACQ_POLL && stop_pend) begin
            st <= ST_IDLE;
          end else if (!rdy_i && !slot_full_i) begin
            st <= (acq == ACQ_STREAM) ? ST_READ_DATA : ST_READ_CMD;
          end
        end
        ST_READ_CMD: if (sh_done_i) st <= ST_READ_DATA;
        ST_READ_DATA: begin
          if (sh_done_i) st <= (acq == ACQ_SINGLE) ? ST_IDLE : ST_WAIT_RDY;
        end
        ST_STREAM_OFF: if (sh_done_i) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_OVR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_o |=> !overrun_o); // R10
  AST_POWERUP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_POWERUP) |-> !sh_active_i); // R4

endmodule

// File: rtl/adc_host_seq.sv
module adc_host_seq
  import adc_host_pkg::*;
#(
  parameter int          RESULT_W  = 24,
  parameter int          CLK_DIV   = 2,
  parameter int          PWRUP_CYC = 50000,
  parameter logic [12:0] MODE_LOW  = 13'h000A
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          mode_i,
  input  logic                start_i,
  input  logic                stop_i,
  input  logic                rst_seq_i,
  output logic                busy_o,
  output logic                cs_n_o,
  output logic                sclk_o,
  output logic                din_o,
  input  logic                dout_rdy_i,
  output logic [RESULT_W-1:0] res_data_o,
  output logic                res_valid_o,
  input  logic                res_ready_i,
  output logic                overrun_o
);
  logic                sh_go, sh_active, sh_done, load;
  logic [NBITS_W-1:0]  sh_nbits;
  logic [SHIFT_W-1:0]  sh_word;
  logic [RESULT_W-1:0] rx;

  adc_seq_ctrl #(
    .RESULT_W (RESULT_W),
    .PWRUP_CYC(PWRUP_CYC),
    .MODE_LOW (MODE_LOW)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_i     (mode_i),
    .start_i    (start_i),
    .stop_i     (stop_i),
    .rst_seq_i  (rst_seq_i),
    .rdy_i      (dout_rdy_i),
    .slot_full_i(res_valid_o),
    .sh_active_i(sh_active),
    .sh_done_i  (sh_done),
    .sh_go_o    (sh_go),
    .sh_nbits_o (sh_nbits),
    .sh_word_o  (sh_word),
    .load_o     (load),
    .cs_n_o     (cs_n_o),
    .busy_o     (busy_o),
    .overrun_o  (overrun_o)
  );

  adc_bit_shifter #(.CLK_DIV(CLK_DIV), .RX_W(RESULT_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .go_i    (sh_go),
    .nbits_i (sh_nbits),
    .word_i  (sh_word),
    .sdo_i   (dout_rdy_i),
    .active_o(sh_active),
    .done_o  (sh_done),
    .sclk_o  (sclk_o),
    .sdi_o   (din_o),
    .rx_o    (rx)
  );

  adc_result_buf #(.W(RESULT_W)) u_buf (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (load),
    .data_i (rx),
    .ready_i(res_ready_i),
    .valid_o(res_valid_o),
    .data_o (res_data_o)
  );

  AST_SCLK_WHILE_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_o |-> sclk_o); // R2
  AST_DIN_WHILE_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_o |-> !din_o); // R7

endmodule

// File: tb/sim_adc_host_seq.sv
module sim_adc_host_seq;
  localparam int W   = 24;
  localparam int DIV = 2;
  localparam int PWR = 40;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic         rst_n = 1'b0;
  logic [1:0]   mode = 2'd0;
  logic         start = 1'b0, stop = 1'b0, rst_seq = 1'b0, res_ready = 1'b0;
  logic         busy_o, cs_n_o, sclk_o, din_o, res_valid_o, overrun_o;
  logic [W-1:0] res_data_o;
  logic         dout_rdy = 1'b1;

  adc_host_seq #(.RESULT_W(W), .CLK_DIV(DIV), .PWRUP_CYC(PWR)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .start_i(start), .stop_i(stop),
    .rst_seq_i(rst_seq), .busy_o(busy_o), .cs_n_o(cs_n_o), .sclk_o(sclk_o),
    .din_o(din_o), .dout_rdy_i(dout_rdy), .res_data_o(res_data_o),
    .res_valid_o(res_valid_o), .res_ready_i(res_ready), .overrun_o(overrun_o)
  );

  int checks = 0, errors = 0, ovr_cnt = 0;
  int cyc = 0;
  bit bit_q[$];

  // converter model state (written only by the monitor, requests from stimulus)
  int          skip = 8;
  logic [31:0] conv_word = '0;
  int          conv_req = 0, conv_seen = 0;
  logic [31:0] cw = '0;
  int          falls = 0, low_run = 0;
  bit          armed = 0;
  logic        prev_sclk = 1'b1, prev_valid = 1'b0, prev_ready = 1'b0;
  logic [W-1:0] prev_data = '0;

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] bits_at(int start_i, int n);
    logic [31:0] v = '0;
    for (int i = 0; i < n; i++) v = {v[30:0], bit_q[start_i + i]};
    return v;
  endfunction

  // per-clock reference model and comparison
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (cs_n_o) begin
        armed = 0;
        dout_rdy = 1'b1;
      end
      if (conv_req != conv_seen) begin
        conv_seen = conv_req;
        cw = conv_word;
        armed = 1;
        falls = 0;
        dout_rdy = 1'b0;
      end
      if (prev_sclk && !sclk_o && !cs_n_o && armed) begin
        falls++;
        if (falls > skip && falls <= skip + W) dout_rdy = cw[W - 1 - (falls - skip - 1)];
      end
      if (!prev_sclk && sclk_o && !cs_n_o) begin
        bit_q.push_back(din_o);
        if (armed && falls >= skip + W) begin
          armed = 0;
          dout_rdy = 1'b1;
        end
        chk(low_run == DIV, "R2 sclk low phase", low_run, DIV);
      end
      low_run = sclk_o ? 0 : low_run + 1;
      if (cs_n_o && !sclk_o) chk(0, "R2 sclk idle", sclk_o, 1);
      if (cs_n_o && din_o)   chk(0, "R7 din idle", din_o, 0);
      if (prev_valid && !prev_ready)
        chk(res_valid_o && res_data_o == prev_data, "R9 hold", res_data_o, prev_data);
      if (overrun_o) ovr_cnt++;
    end
    prev_sclk  = sclk_o;
    prev_valid = res_valid_o;
    prev_ready = res_ready;
    prev_data  = res_data_o;
  end

  always @(negedge clk) begin
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic convert(logic [31:0] w);
    conv_word = w;
    conv_req++;
    tick(1);
  endtask
  task automatic wait_bits(int n);
    while (bit_q.size() < n) @(negedge clk);
  endtask
  task automatic wait_idle();
    while (busy_o) @(negedge clk);
  endtask
  task automatic wait_valid();
    while (!res_valid_o) @(negedge clk);
  endtask
  task automatic take(logic [31:0] exp, string req);
    wait_valid();
    chk(res_data_o == exp[W-1:0], req, res_data_o, exp);
    res_ready = 1'b1;
    tick(1);
    res_ready = 1'b0;
  endtask

  initial begin
    int t0;
    tick(3);
    // R1 reset state
    chk(cs_n_o == 1 && sclk_o == 1 && din_o == 0, "R1 pins", {cs_n_o, sclk_o, din_o}, 3'b110);
    chk(res_valid_o == 0 && busy_o == 0 && overrun_o == 0, "R1 status",
        {res_valid_o, busy_o, overrun_o}, 0);
    rst_n = 1'b1;
    tick(2);

    // R3 interface reset
    rst_seq = 1'b1; tick(1); rst_seq = 1'b0;
    wait_idle(); tick(3);
    chk(bit_q.size() == 32, "R3 length", bit_q.size(), 32);
    chk(bits_at(0, 32) == 32'hFFFF_FFFF, "R3 ones", bits_at(0, 32), 32'hFFFF_FFFF);
    chk(cs_n_o == 1, "R3 release", cs_n_o, 1);

    // R4 single conversion
    bit_q.delete(); skip = 8; mode = 2'd0;
    start = 1'b1; tick(1); start = 1'b0;
    wait_bits(24); t0 = cyc;
    chk(bits_at(0, 24) == 32'h0008200A, "R4 mode write", bits_at(0, 24), 32'h0008200A);
    convert(32'h00A5C31E);
    mode = 2'd2; start = 1'b1; rst_seq = 1'b1; tick(1); start = 1'b0; rst_seq = 1'b0; // R12
    mode = 2'd0;
    wait_bits(25);
    chk((cyc - t0) >= PWR, "R4 power-up wait", cyc - t0, PWR);
    take(32'h00A5C31E, "R11 single result");
    wait_idle(); tick(20);
    chk(bits_at(24, 8) == 32'h58, "R4 read command", bits_at(24, 8), 32'h58);
    chk(bits_at(32, W) == 0, "R7 din low in read", bits_at(32, W), 0);
    chk(bit_q.size() == 32 + W, "R12 busy start ignored", bit_q.size(), 32 + W);
    chk(cs_n_o == 1 && busy_o == 0, "R4 release", {cs_n_o, busy_o}, 2'b10);
    mode = 2'd3; start = 1'b1; tick(1); start = 1'b0; tick(10);
    chk(busy_o == 0 && bit_q.size() == 32 + W, "R12 mode 3", busy_o, 0);

    // R5 polled continuous, R9/R10 back-pressure and overrun
    bit_q.delete(); skip = 8; mode = 2'd1;
    start = 1'b1; tick(1); start = 1'b0;
    wait_bits(24);
    chk(bits_at(0, 24) == 32'h0008000A, "R5 mode write", bits_at(0, 24), 32'h0008000A);
    convert(32'h0012F0E1);
    take(32'h0012F0E1, "R11 polled result");
    chk(bits_at(24, 8) == 32'h58, "R5 read command", bits_at(24, 8), 32'h58);
    chk(bits_at(32, W) == 0, "R7 polled din low", bits_at(32, W), 0);
    tick(4);
    convert(32'h00800001);
    wait_valid();
    convert(32'h007FFFFE);
    tick(30);
    chk(ovr_cnt == 1, "R10 overrun pulse", ovr_cnt, 1);
    chk(res_data_o == 24'h800001, "R9 held word", res_data_o, 32'h00800001);
    chk(bit_q.size() == 24 + 2 * (8 + W), "R9 no read while full", bit_q.size(), 24 + 2 * (8 + W));
    take(32'h00800001, "R9 held result");
    take(32'h007FFFFE, "R11 result after release");
    chk(ovr_cnt == 1, "R10 single pulse", ovr_cnt, 1);
    chk(cs_n_o == 0, "R5 stays selected", cs_n_o, 0);
    stop = 1'b1; tick(1); stop = 1'b0;
    wait_idle(); tick(2);
    chk(cs_n_o == 1, "R5 stop", cs_n_o, 1);

    // R6 streaming, R8 exit
    bit_q.delete(); skip = 0; mode = 2'd2;
    start = 1'b1; tick(1); start = 1'b0;
    wait_bits(32);
    chk(bits_at(0, 32) == 32'h08000A5C, "R6 entry", bits_at(0, 32), 32'h08000A5C);
    tick(4);
    convert(32'h00C3A55A);
    take(32'h00C3A55A, "R11 stream result");
    tick(10);
    chk(bit_q.size() == 32 + W, "R6 no command", bit_q.size(), 32 + W);
    chk(bits_at(32, W) == 0, "R7 stream din low", bits_at(32, W), 0);
    stop = 1'b1; tick(1); stop = 1'b0;
    tick(20);
    chk(busy_o == 1 && bit_q.size() == 32 + W, "R8 waits for ready", bit_q.size(), 32 + W);
    convert(32'h00111111);
    wait_idle(); tick(4);
    chk(bit_q.size() == 32 + W + 8, "R8 exit length", bit_q.size(), 32 + W + 8);
    chk(bits_at(32 + W, 8) == 32'h58, "R8 exit byte", bits_at(32 + W, 8), 32'h58);
    chk(res_valid_o == 0 && cs_n_o == 1, "R8 idle after exit", {res_valid_o, cs_n_o}, 2'b01);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule